// File: doc/BRIEF.md
# Disk Interface Status Register

This block is the read-only status register of a floppy-style disk controller. A host read of its address returns a byte built from the live state of the drive interface: the two motor-enable outputs, the write-gate output, the drive-select-0 control bit, and two toggle flags. One toggle flag follows the serial read-data line and the other follows the serial write-data line. Both serial lines are asynchronous and active low. Each passes through a synchronizer, and its flag inverts once for every rising (inactive) edge. Firmware that polls the register can therefore tell whether data is moving on either line.

A mode input chooses between two compatibility behaviours. In the PS/2-style mode the register drives the bus on every read. In the AT-style mode a read of this address keeps the output enable low, so the host bus stays at high impedance. A hardware reset clears the toggle flags and the synchronizers. A software reset leaves the whole register untouched.

Top module: `disk_status_reg`

## Requirements
- R1: Bits 1:0 of the read byte equal {mot1_i, mot0_i} in the same cycle, with no register delay.
- R2: Bit 2 of the read byte equals wgate_i in the same cycle.
- R3: Bit 3 inverts once for each rising edge of rdata_n. Falling edges do not change it. Because of the two-flop synchronizer and the edge register, the new value is visible after the third rising clock edge that samples rdata_n high.
- R4: Bit 4 behaves the same way as R3, but follows wdata_n.
- R5: Bit 5 equals dsel_i, the drive-select-0 bit of the digital output register, in the same cycle.
- R6: Bits 7:6 always read as 1.
- R7: After a hardware reset (rst_n low), with mot0_i, mot1_i, wgate_i and dsel_i low, a read returns 8'hC0. Both toggle flags are 0.
- R8: Holding sw_rst high for any number of cycles changes no bit of the read byte.
- R9: With ps2_mode = 1, rd_oe is high whenever rd_stb is high and addr equals REG_OFS (default 1).
- R10: With ps2_mode = 0, rd_oe stays low, including during a read of this register's address.
- R11: When rd_stb is low or addr differs from REG_OFS, rd_oe is low and rd_data is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| sw_rst | input | 1 | Software reset of the controller; no effect on this register |
| ps2_mode | input | 1 | 1 = PS/2-style mode (drive on read), 0 = AT-style mode (bus left undriven) |
| addr | input | ADDR_W (3) | Register offset within the controller |
| rd_stb | input | 1 | Host read strobe |
| mot0_i | input | 1 | Motor-enable 0 output pin state, active high |
| mot1_i | input | 1 | Motor-enable 1 output pin state, active high |
| wgate_i | input | 1 | Write-gate output pin state, active high |
| dsel_i | input | 1 | Drive-select-0 bit of the digital output register |
| rdata_n | input | 1 | Serial read-data line, asynchronous, active low |
| wdata_n | input | 1 | Serial write-data line, asynchronous, active low |
| rd_data | output | 8 | Read data byte |
| rd_oe | output | 1 | Output enable for rd_data onto the host bus |

## Verification
The bench builds the block with its defaults: a 3-bit offset, register offset 1, a two-stage synchronizer, an idle level of 1, and toggle flags that persist across a software reset. With these values the three-edge latency from a serial line to its flag is short enough to cover short pulses, pulses that each last one cycle, and long holds on both lines in the same run. Reads at all eight offsets reach the address decode, including its miss cases.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   localparam int STAT_W = 8;

   typedef struct packed {
      logic rsvd_hi;
      logic rsvd_lo;
      logic dsel;
      logic wtog;
      logic rtog;
      logic wgate;
      logic mot1;
      logic mot0;
   } stat_t;

   localparam int LINE_RD  = 0;
   localparam int LINE_WR  = 1;
   localparam int N_LINES  = 2;
endpackage

// File: rtl/dsr_line_toggle.sv
module dsr_line_toggle #(
   parameter int SYNC_STAGES = 2,
   parameter bit IDLE_LVL    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic line_i,
   output logic tog_o
);
   localparam int MSB = SYNC_STAGES - 1;

   logic [MSB:0] sync_q;
   logic         prev_q;
   logic         tog_q;
   logic         rise;

   assign rise = sync_q[MSB] & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{IDLE_LVL}};
         prev_q <= IDLE_LVL;
         tog_q  <= 1'b0;
      end else begin
         sync_q <= {sync_q[MSB-1:0], line_i};
         prev_q <= sync_q[MSB];
         if (clr_i)
            tog_q <= 1'b0;
         else if (rise)
            tog_q <= ~tog_q;
      end
   end

   assign tog_o = tog_q;
endmodule

// File: rtl/dsr_read_port.sv
module dsr_read_port
   import dsr_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int REG_OFS = 1
) (
   input  logic              ps2_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_stb,
   input  stat_t             stat_i,
   output logic [STAT_W-1:0] rd_data,
   output logic              rd_oe
);
   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

   logic hit;

   always_comb begin
      hit     = rd_stb && (addr == OFS);
      rd_data = hit ? stat_i : '0;
      rd_oe   = hit && ps2_mode;
   end
endmodule

// File: rtl/disk_status_reg.sv
module disk_status_reg
   import dsr_pkg::*;
#(
   parameter int ADDR_W           = 3,
   parameter int REG_OFS          = 1,
   parameter int SYNC_STAGES      = 2,
   parameter bit LINE_IDLE        = 1'b1,
   parameter bit KEEP_TOG_ON_SWRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              ps2_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_stb,
   input  logic              mot0_i,
   input  logic              mot1_i,
   input  logic              wgate_i,
   input  logic              dsel_i,
   input  logic              rdata_n,
   input  logic              wdata_n,
   output logic [7:0]        rd_data,
   output logic              rd_oe
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("disk_status_reg: SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 1 || REG_OFS < 0 || REG_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
         $error("disk_status_reg: REG_OFS outside the address range");
      end
   endgenerate

   logic [N_LINES-1:0] lines;
   logic [N_LINES-1:0] togs;
   logic               tog_clr;

   assign lines[LINE_RD] = rdata_n;
   assign lines[LINE_WR] = wdata_n;

   generate
      if (KEEP_TOG_ON_SWRST) begin : g_keep
         assign tog_clr = sw_rst & 1'b0;
      end else begin : g_clear
         assign tog_clr = sw_rst;
      end

      for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
         dsr_line_toggle #(
            .SYNC_STAGES (SYNC_STAGES),
            .IDLE_LVL    (LINE_IDLE)
         ) u_tog (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (tog_clr),
            .line_i (lines[gi]),
            .tog_o  (togs[gi])
         );
      end
   endgenerate

   stat_t stat;

   always_comb begin
      stat.rsvd_hi = 1'b1;
      stat.rsvd_lo = 1'b1;
      stat.dsel    = dsel_i;
      stat.wtog    = togs[LINE_WR];
      stat.rtog    = togs[LINE_RD];
      stat.wgate   = wgate_i;
      stat.mot1    = mot1_i;
      stat.mot0    = mot0_i;
   end

   dsr_read_port #(
      .ADDR_W  (ADDR_W),
      .REG_OFS (REG_OFS)
   ) u_rd (
      .ps2_mode (ps2_mode),
      .addr     (addr),
      .rd_stb   (rd_stb),
      .stat_i   (stat),
      .rd_data  (rd_data),
      .rd_oe    (rd_oe)
   );
endmodule

// File: rtl/dsr_chk.sv
module dsr_chk #(
   parameter int ADDR_W  = 3,
   parameter int REG_OFS = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ps2_mode,
   input logic [ADDR_W-1:0] addr,
   input logic              rd_stb,
   input logic              mot0_i,
   input logic              mot1_i,
   input logic              wgate_i,
   input logic              dsel_i,
   input logic [7:0]        rd_data,
   input logic              rd_oe
);
   AST_MOTOR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> rd_data[1:0] == {mot1_i, mot0_i}); // R1
   AST_WGATE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> rd_data[2] == wgate_i); // R2
   AST_DSEL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> rd_data[5] == dsel_i); // R5
   AST_RSVD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> rd_data[7:6] == 2'b11); // R6
   AST_HWRST_TOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_n) && rd_oe) |-> rd_data[4:3] == 2'b00); // R7
   AST_PS2_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (ps2_mode && rd_stb && addr == ADDR_W'(REG_OFS)) |-> rd_oe); // R9
   AST_AT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ps2_mode |-> !rd_oe); // R10
   AST_MISS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb || addr != ADDR_W'(REG_OFS)) |-> (!rd_oe && rd_data == 8'h00)); // R11
endmodule

bind disk_status_reg dsr_chk #(
   .ADDR_W  (ADDR_W),
   .REG_OFS (REG_OFS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ps2_mode (ps2_mode),
   .addr     (addr),
   .rd_stb   (rd_stb),
   .mot0_i   (mot0_i),
   .mot1_i   (mot1_i),
   .wgate_i  (wgate_i),
   .dsel_i   (dsel_i),
   .rd_data  (rd_data),
   .rd_oe    (rd_oe)
);

// File: tb/sim_disk_status_reg.sv
`timescale 1ns/1ps
module sim_disk_status_reg;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_rst = 1'b0;
   logic       ps2_mode = 1'b1;
   logic [2:0] addr = 3'd1;
   logic       rd_stb = 1'b1;
   logic       mot0_i = 1'b0, mot1_i = 1'b0, wgate_i = 1'b0, dsel_i = 1'b0;
   logic       rdata_n = 1'b1, wdata_n = 1'b1;
   logic [7:0] rd_data;
   logic       rd_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   disk_status_reg u0 (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .ps2_mode(ps2_mode),
      .addr(addr), .rd_stb(rd_stb), .mot0_i(mot0_i), .mot1_i(mot1_i),
      .wgate_i(wgate_i), .dsel_i(dsel_i), .rdata_n(rdata_n),
      .wdata_n(wdata_n), .rd_data(rd_data), .rd_oe(rd_oe)
   );

   // Reference model: sample history of each serial line, newest first
   int  hr[$];
   int  hw[$];
   bit  m_rt = 0, m_wt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         hr.delete(); hw.delete();
         for (int i = 0; i <= SYNC; i++) begin hr.push_back(1); hw.push_back(1); end
         m_rt = 0; m_wt = 0;
      end else begin
         if (hr[SYNC-1] == 1 && hr[SYNC] == 0) m_rt = ~m_rt;
         if (hw[SYNC-1] == 1 && hw[SYNC] == 0) m_wt = ~m_wt;
         hr.push_front(int'(rdata_n)); void'(hr.pop_back());
         hw.push_front(int'(wdata_n)); void'(hw.pop_back());
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare_all();
      bit hit = rd_stb && addr == 3'd1;
      if (!hit) begin
         chk(rd_data == 8'h00 && !rd_oe, "R11", {rd_oe, rd_data}, 0);
      end else begin
         chk(rd_data[1:0] == {mot1_i, mot0_i}, "R1", rd_data[1:0], {mot1_i, mot0_i});
         chk(rd_data[2] == wgate_i, "R2", rd_data[2], wgate_i);
         chk(rd_data[3] == m_rt, "R3", rd_data[3], m_rt);
         chk(rd_data[4] == m_wt, "R4", rd_data[4], m_wt);
         chk(rd_data[5] == dsel_i, "R5", rd_data[5], dsel_i);
         chk(rd_data[7:6] == 2'b11, "R6", rd_data[7:6], 3);
         if (ps2_mode) chk(rd_oe == 1'b1, "R9", rd_oe, 1);
         else          chk(rd_oe == 1'b0, "R10", rd_oe, 0);
      end
   endtask

   // one clock: new inputs applied at the falling edge, then compared
   task automatic cyc();
      @(negedge clk);
      #1;
      if (rst_n) compare_all();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #500000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] snap;
      bit t0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R7: reset value
      chk(rd_data == 8'hC0 && rd_oe, "R7", rd_data, 8'hC0);
      repeat (3) cyc();

      // R12-style edge checks on read-data: falling edge leaves R3 flag alone
      t0 = m_rt;
      @(negedge clk); rdata_n = 1'b0;
      repeat (6) cyc();
      chk(rd_data[3] == t0, "R3", rd_data[3], t0);
      @(negedge clk); rdata_n = 1'b1;
      #1; chk(rd_data[3] == t0, "R3", rd_data[3], t0);
      cyc(); cyc();
      chk(rd_data[3] == t0, "R3", rd_data[3], t0);
      cyc();
      chk(rd_data[3] == ~t0, "R3", rd_data[3], ~t0);

      // R4: single-cycle low pulse on write-data
      t0 = m_wt;
      @(negedge clk); wdata_n = 1'b0;
      @(negedge clk); wdata_n = 1'b1;
      repeat (5) cyc();
      chk(rd_data[4] == ~t0, "R4", rd_data[4], ~t0);

      // random traffic, PS/2 mode, mostly reading this register
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         mot0_i  = 1'($urandom);
         mot1_i  = 1'($urandom);
         wgate_i = 1'($urandom);
         dsel_i  = 1'($urandom);
         if ($urandom_range(3) == 0) rdata_n = ~rdata_n;
         if ($urandom_range(2) == 0) wdata_n = ~wdata_n;
         rd_stb  = ($urandom_range(7) != 0);
         addr    = ($urandom_range(3) == 0) ? 3'($urandom) : 3'd1;
         ps2_mode = (i < 2000) ? 1'b1 : 1'($urandom);
         #1;
         compare_all();
      end

      // R8: software reset leaves every bit unchanged
      @(negedge clk);
      ps2_mode = 1'b1; rd_stb = 1'b1; addr = 3'd1;
      rdata_n = 1'b1; wdata_n = 1'b1;
      mot0_i = 1'b1; mot1_i = 1'b0; wgate_i = 1'b1; dsel_i = 1'b1;
      repeat (5) cyc();
      snap = rd_data;
      @(negedge clk); sw_rst = 1'b1;
      repeat (4) cyc();
      chk(rd_data == snap, "R8", rd_data, snap);
      @(negedge clk); sw_rst = 1'b0;
      #1; chk(rd_data == snap, "R8", rd_data, snap);

      // R10: AT mode read of this address is undriven
      @(negedge clk); ps2_mode = 1'b0;
      #1; chk(rd_oe == 1'b0, "R10", rd_oe, 0);

      // R7: hardware reset with live inputs low clears toggles
      @(negedge clk);
      ps2_mode = 1'b1; mot0_i = 0; mot1_i = 0; wgate_i = 0; dsel_i = 0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1; chk(rd_data == 8'hC0, "R7", rd_data, 8'hC0);
      repeat (4) cyc();
      finish_run();
   end
endmodule